// File: doc/BRIEF.md
# Three-Wire Shutter Control Register

This block takes shutter settings from a host over three wires: a data line, a shift clock and a load strobe. Every rising edge of the shift clock moves one data bit into a 13-stage register. A rising edge of the load strobe copies the register into holding registers. Four of the held bits drive general-purpose outputs. The other nine bits form an unsigned shutter code that goes to the sensor timing logic. The last stage of the register is also driven out as serial data, so that several such blocks can be chained on one data line.

The three wire inputs may change at any time relative to the system clock. Each one passes through a synchronizer of `SYNC_STAGES` flops, and edges are then detected in the system clock domain. An active-low reset puts the held shutter code into its "shutter off" value and clears the general-purpose outputs and the shift register. While reset is held, the wire inputs have no effect.

A frame is sent most significant bit first. The four general-purpose bits come first, then the shutter code from its MSB down to its LSB. The last bit shifted in is therefore the code's LSB.

Top module: `shutter_serial_reg`

## Requirements
- R1: While `rst_n` is low, `aux_out` is 0, `shutter_code` equals `OFF_CODE` (default 511, all ones), and `ser_out` is 0.
- R2: A frame is sent MSB first: after 13 rising shift-clock edges and a load, `aux_out[3:0]` holds bits 1 to 4 of the frame in that order, and `shutter_code[8:0]` holds bits 5 to 13, with the 13th bit as `shutter_code[0]`.
- R3: When the shift clock has no rising edge, the register keeps its contents. Changes on the data line alone and falling shift-clock edges do not alter `ser_out` or the value taken by the next load.
- R4: A rising edge of the load strobe copies register bits 12..9 to `aux_out` and register bits 8..0 to `shutter_code`.
- R5: Between loads, `aux_out` and `shutter_code` keep their values, even while new bits are being shifted in.
- R6: `ser_out` is the MSB stage of the register. While a new 13-bit frame is shifted in, the previous frame appears on `ser_out` MSB first, one bit per shift-clock edge.
- R7: While `rst_n` is low, shift-clock edges, data and load edges are all ignored. After release, a load without any new shifting yields an all-zero register.
- R8: A change on any wire input acts on the register or the outputs at the (`SYNC_STAGES`+1)-th rising system clock edge after it.
- R9: A load strobe held high causes only one load, at its rising edge. Shifting during the high level, or the falling edge, loads nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Shift clock; data is sampled on its rising edge |
| ser_dat | input | 1 | Serial data |
| ser_ld | input | 1 | Load strobe; acts on its rising edge |
| ser_out | output | 1 | MSB stage of the shift register, for chaining |
| aux_out | output | AUX_W | Held general-purpose bits |
| shutter_code | output | CODE_W | Held shutter code |

## Verification
The bench builds the block with its default parameters: 4 general-purpose bits, a 9-bit code and two synchronizer stages. This makes a 13-bit frame, so the bench can reach both code extremes, 0 and 511, and observe a complete previous frame leaving on `ser_out`. With two synchronizer stages, the exact three-edge latency of R8 can be followed clock by clock. A behavioural queue model compares every output on every cycle, including during reset, during a held load strobe, and while the data line toggles without any shift clock.

// File: rtl/ssr_pkg.sv
package ssr_pkg;
    localparam int AUX_W_DEF  = 4;
    localparam int CODE_W_DEF = 9;
    localparam int SYNC_DEF   = 2;

    function automatic int frame_width(input int aux_w, input int code_w);
        return aux_w + code_w;
    endfunction
endpackage

// File: rtl/ssr_sync.sv
module ssr_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    typedef struct packed {
        logic [STAGES-1:0][W-1:0] stg;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.stg[0] = din;
        for (int k = 1; k < STAGES; k++) begin
            st_d.stg[k] = st_q.stg[k-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout = st_q.stg[STAGES-1];
endmodule

// File: rtl/ssr_shift.sv
module ssr_shift #(
    parameter int FRAME_W = 13
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sclk_lvl,
    input  logic               dat_lvl,
    output logic [FRAME_W-1:0] frame,
    output logic               sdo
);
    typedef struct packed {
        logic [FRAME_W-1:0] frame;
        logic               clk_prev;
    } shift_t;

    shift_t st_d, st_q;
    logic   shift_en;

    assign shift_en = sclk_lvl & ~st_q.clk_prev;

    always_comb begin
        st_d          = st_q;
        st_d.clk_prev = sclk_lvl;
        if (shift_en) begin
            st_d.frame = {st_q.frame[FRAME_W-2:0], dat_lvl};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign frame = st_q.frame;
    assign sdo   = st_q.frame[FRAME_W-1];

    // R2: a detected edge moves every stage up by one and takes in the data bit
    p_shift_r2: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> (frame[0] == $past(dat_lvl)) &&
                     (frame[FRAME_W-1:1] == $past(frame[FRAME_W-2:0])));

    // R3: with no edge the register holds
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(frame));

    // R6: the serial output follows the stage just below the MSB after a shift
    p_sdo_r6: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> sdo == $past(frame[FRAME_W-2]));
endmodule

// File: rtl/ssr_latch.sv
module ssr_latch #(
    parameter int                AUX_W    = 4,
    parameter int                CODE_W   = 9,
    parameter logic [CODE_W-1:0] OFF_CODE = '1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ld_lvl,
    input  logic [AUX_W+CODE_W-1:0]  frame,
    output logic [AUX_W-1:0]         aux,
    output logic [CODE_W-1:0]        code
);
    localparam int FRAME_W = AUX_W + CODE_W;

    typedef struct packed {
        logic [AUX_W-1:0]  aux;
        logic [CODE_W-1:0] code;
        logic              ld_prev;
    } hold_t;

    hold_t st_d, st_q;
    logic  load;

    assign load = ld_lvl & ~st_q.ld_prev;

    always_comb begin
        st_d         = st_q;
        st_d.ld_prev = ld_lvl;
        if (load) begin
            st_d.aux  = frame[FRAME_W-1 -: AUX_W];
            st_d.code = frame[CODE_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.aux     <= '0;
            st_q.code    <= OFF_CODE;
            st_q.ld_prev <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign aux  = st_q.aux;
    assign code = st_q.code;

    // R4: a load edge copies the register fields
    p_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (code == $past(frame[CODE_W-1:0])) &&
                 (aux == $past(frame[FRAME_W-1 -: AUX_W])));

    // R5: without a load edge the held values stay put
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(code) && $stable(aux));
endmodule

// File: rtl/shutter_serial_reg.sv
module shutter_serial_reg #(
    parameter int                AUX_W       = ssr_pkg::AUX_W_DEF,
    parameter int                CODE_W      = ssr_pkg::CODE_W_DEF,
    parameter int                SYNC_STAGES = ssr_pkg::SYNC_DEF,
    parameter logic [CODE_W-1:0] OFF_CODE    = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk,
    input  logic              ser_dat,
    input  logic              ser_ld,
    output logic              ser_out,
    output logic [AUX_W-1:0]  aux_out,
    output logic [CODE_W-1:0] shutter_code
);
    localparam int FRAME_W = ssr_pkg::frame_width(AUX_W, CODE_W);

    logic [2:0]         wires_raw, wires_sync;
    logic [FRAME_W-1:0] frame;

    assign wires_raw = {ser_ld, ser_dat, ser_clk};

    ssr_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (wires_raw),
        .dout (wires_sync)
    );

    ssr_shift #(.FRAME_W(FRAME_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .sclk_lvl(wires_sync[0]),
        .dat_lvl (wires_sync[1]),
        .frame   (frame),
        .sdo     (ser_out)
    );

    ssr_latch #(.AUX_W(AUX_W), .CODE_W(CODE_W), .OFF_CODE(OFF_CODE)) u_latch (
        .clk   (clk),
        .rst_n (rst_n),
        .ld_lvl(wires_sync[2]),
        .frame (frame),
        .aux   (aux_out),
        .code  (shutter_code)
    );
endmodule

// File: tb/shutter_serial_reg_test.sv
module shutter_serial_reg_test;
    localparam int STG = 2;
    localparam int FW  = 13;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 1'b0, ser_dat = 1'b0, ser_ld = 1'b0;
    logic ser_out;
    logic [3:0] aux_out;
    logic [8:0] shutter_code;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    shutter_serial_reg #(.AUX_W(4), .CODE_W(9), .SYNC_STAGES(STG)) uut (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
        .ser_ld(ser_ld), .ser_out(ser_out), .aux_out(aux_out),
        .shutter_code(shutter_code)
    );

    // behavioural reference model: queue of delayed wire samples
    logic [2:0]    pipe[$];
    logic [FW-1:0] m_frame;
    logic [3:0]    m_aux;
    logic [8:0]    m_code;
    logic          m_cprev, m_lprev;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe = {};
            for (int i = 0; i < STG; i++) pipe.push_back(3'b000);
            m_frame = '0; m_aux = '0; m_code = 9'h1FF;
            m_cprev = 1'b0; m_lprev = 1'b0;
        end else begin
            logic [2:0] f;
            f = pipe[0];
            if (f[2] && !m_lprev) begin
                m_aux  = m_frame[12:9];
                m_code = m_frame[8:0];
            end
            if (f[0] && !m_cprev) m_frame = {m_frame[FW-2:0], f[1]};
            m_cprev = f[0];
            m_lprev = f[2];
            void'(pipe.pop_front());
            pipe.push_back({ser_ld, ser_dat, ser_clk});
        end
    end

    // R8: cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        checks++;
        if (ser_out !== m_frame[FW-1] || aux_out !== m_aux || shutter_code !== m_code) begin
            errors++;
            $display("FAIL R8 model: actual sdo=%0h aux=%0h code=%0h expected sdo=%0h aux=%0h code=%0h",
                     ser_out, aux_out, shutter_code, m_frame[FW-1], m_aux, m_code);
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_frame(input logic [FW-1:0] f, input logic [FW-1:0] old, input bit chk);
        for (int i = FW - 1; i >= 0; i--) begin
            ser_dat = f[i];
            wait_n(4);
            if (chk) check("R6 previous frame on ser_out", ser_out, old[i]);
            ser_clk = 1'b1;
            wait_n(4);
            ser_clk = 1'b0;
            wait_n(4);
        end
    endtask

    task automatic strobe();
        ser_ld = 1'b1;
        wait_n(6);
        ser_ld = 1'b0;
        wait_n(6);
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [FW-1:0] f1, f2, f3, f4, f5;
        f1 = {4'hA, 9'd104};
        f2 = {4'h5, 9'd0};
        f3 = {4'hF, 9'h1FF};
        f4 = {4'h3, 9'd304};
        f5 = {4'h6, 9'd155};

        wait_n(5);
        check("R1 aux in reset", aux_out, 0);
        check("R1 code in reset", shutter_code, 9'h1FF);
        check("R1 sdo in reset", ser_out, 0);
        rst_n = 1'b1;
        wait_n(3);

        send_frame(f1, '0, 1'b1);
        check("R5 aux before load", aux_out, 0);
        check("R5 code before load", shutter_code, 9'h1FF);
        strobe();
        check("R4 aux loaded", aux_out, 4'hA);
        check("R4 code loaded", shutter_code, 9'd104);
        check("R6 sdo is MSB", ser_out, f1[12]);

        // R3: data toggles with no shift clock
        for (int i = 0; i < 10; i++) begin
            ser_dat = ~ser_dat;
            wait_n(4);
        end
        check("R3 sdo held", ser_out, f1[12]);
        strobe();
        check("R3 aux unchanged frame", aux_out, 4'hA);
        check("R3 code unchanged frame", shutter_code, 9'd104);

        send_frame(f2, f1, 1'b1);
        check("R5 code held while shifting", shutter_code, 9'd104);
        strobe();
        check("R2 code zero boundary", shutter_code, 9'd0);
        check("R2 aux order", aux_out, 4'h5);

        // R9: strobe held high through a whole frame
        ser_ld = 1'b1;
        wait_n(6);
        send_frame(f3, f2, 1'b1);
        check("R9 no load during high level", shutter_code, 9'd0);
        ser_ld = 1'b0;
        wait_n(6);
        check("R9 no load on falling edge", aux_out, 4'h5);
        strobe();
        check("R4 code max boundary", shutter_code, 9'h1FF);
        check("R4 aux all ones", aux_out, 4'hF);

        send_frame(f4, f3, 1'b1);
        strobe();
        check("R2 code bit order", shutter_code, 9'd304);
        check("R2 aux bit order", aux_out, 4'h3);

        // R7: activity during reset is ignored
        #3 rst_n = 1'b0;
        wait_n(2);
        send_frame(f5, '0, 1'b0);
        strobe();
        check("R7 aux in reset", aux_out, 0);
        check("R7 code in reset", shutter_code, 9'h1FF);
        check("R7 sdo in reset", ser_out, 0);
        #3 rst_n = 1'b1;
        wait_n(3);
        strobe();
        check("R7 empty register after reset", shutter_code, 9'd0);
        check("R7 aux empty after reset", aux_out, 0);

        send_frame(f5, '0, 1'b1);
        strobe();
        check("R4 code after recovery", shutter_code, 9'd155);
        check("R4 aux after recovery", aux_out, 4'h6);

        wait_n(4);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule